// File: doc/BRIEF.md
# Oscillator Divider Settings Calculator

This block turns a requested output frequency and a reference crystal frequency into the three divider settings a programmable clock synthesizer needs. The settings are a power-of-two low-speed output divider (given as its base-two logarithm), an integer high-speed output divider, and a feedback divider ratio in 11.32 fixed-point form. Both frequencies are unsigned 64-bit integers in hertz. The block also reports the VCO frequency that the chosen dividers imply.

A caller places the two frequencies on the inputs and pulses `start` while the engine is idle. The engine first derives the minimum total output division that keeps the VCO at or above its lower limit. It then picks the smallest legal output divider, using the high-speed divider alone wherever that is possible. After that it forms the VCO frequency and divides it by the crystal frequency, one quotient bit per clock. When the work ends, `done` rises and stays high together with the results until the next accepted start. If no legal setting exists, `err` is raised alongside `done`.

Top module: `odc_calc`

## Requirements
- R1: The minimum total ratio is ceil(10 800 000 000 / fOut). The chosen hsDiv * 2^lsLog is the smallest legal product that is not below this minimum, so the VCO sits as close to its lower limit as the divider rules allow.
- R2: lsLog is 0 (low-speed ratio 1) whenever the minimum ratio is at most 2046. Otherwise lsLog is the smallest k in 1..5 for which ceil(minimum / 2^k) ≤ 2046, and hsDiv is that quotient. hsDiv is always in 1..2046.
- R3: When lsLog is 0, an odd high-speed value above 33 is raised to the next even integer (a required 69 becomes 70). Values of 33 and below, and all values when lsLog > 0, are not adjusted.
- R4: fVco equals fOut * hsDiv * 2^lsLog.
- R5: {fbInt, fbFrac} is fVco / fXtal in 11.32 fixed point: fbInt is the integer part on 11 bits, and fbFrac is the remainder scaled by 2^32 and truncated.
- R6: err is raised when the minimum ratio exceeds what lsLog = 5 can reach, that is, when ceil(minimum / 32) > 2046.
- R7: err is raised when fVco exceeds 12 206 718 160 Hz. A fVco reported without err lies within 10 800 000 000 .. 12 206 718 160 Hz.
- R8: err is raised when the integer part of the feedback ratio does not fit in 11 bits (ratio ≥ 2048), or when fOut or fXtal is zero.
- R9: A start seen while idle makes busy high and clears done and err on the next cycle. busy and done are never high together.
- R10: start is ignored while busy. A second start with other inputs does not change the result of the run in progress.
- R11: After done, all outputs hold their values, even if the frequency inputs change, until the next accepted start.
- R12: fOut = 156 750 000 with fXtal = 152 600 000 gives lsLog 0, hsDiv 70, fVco 10 972 500 000 and {fbInt, fbFrac} = 43'h047E756E62A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation (taken only while idle) |
| fOut | input | 64 | Requested output frequency in Hz |
| fXtal | input | 64 | Reference crystal frequency in Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Results are ready; held until the next accepted start |
| err | output | 1 | No legal solution; valid while done is high |
| lsLog | output | 3 | Low-speed divider register: log2 of its ratio |
| hsDiv | output | 11 | High-speed divide ratio |
| fVco | output | 64 | VCO frequency in Hz implied by the dividers |
| fbInt | output | 11 | Integer part of the feedback ratio |
| fbFrac | output | 32 | Fraction of the feedback ratio, times 2^32, truncated |

## Verification
The bench uses the default parameters: a 2046 high-speed ceiling, an odd-value limit of 33 and low-speed exponents up to 5. With these values the real VCO window, the 2046/2047 switch from the high-speed divider to the low-speed divider, and the 33/34/35 parity edge can all be reached with ordinary frequencies. The smallest exponent that fits (lsLog 5) and the first ratio out of reach are one frequency step apart (200 kHz against 100 kHz). Because the divider width is 64 + 32, the full 11.32 result is exercised, including the case of an integer part that overflows.

// File: rtl/odc_pkg.sv
package odc_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic loadIn;     // capture the frequency inputs
    logic divGo;      // launch the serial divider
    logic divSelFb;   // 0: ratio division, 1: feedback division
    logic takeRatio;  // latch ceil(VCO_MIN / fOut)
    logic takePick;   // latch chosen low/high-speed dividers
    logic takeVco;    // latch VCO frequency and its range flag
    logic takeFb;     // latch feedback fixed-point result
  } odc_ctrl_t;

  // Flags from the datapath to the sequencer.
  typedef struct packed {
    logic zeroIn;
    logic divValid;
    logic pickFail;
    logic vcoOver;
    logic fbOver;
  } odc_stat_t;

endpackage

// File: rtl/odc_divider.sv
module odc_divider #(
  parameter int DVD_W = 96,
  parameter int DVS_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quo,
  output logic [DVS_W-1:0] rem,
  output logic             valid
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quoR;   // dividend bits leave at the top, quotient enters at the bottom
  logic [DVS_W-1:0] remR;
  logic [DVS_W-1:0] dvsR;
  logic [CNT_W-1:0] cntR;
  logic             runR;
  logic             validR;

  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;
  logic [DVS_W-1:0] nextRem;

  always_comb begin
    trial   = {remR, quoR[DVD_W-1]};
    diff    = trial - {1'b0, dvsR};
    fits    = trial >= {1'b0, dvsR};
    nextRem = fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR   <= '0;
      remR   <= '0;
      dvsR   <= '0;
      cntR   <= '0;
      runR   <= 1'b0;
      validR <= 1'b0;
    end else if (go) begin
      quoR   <= dividend;
      remR   <= '0;
      dvsR   <= divisor;
      cntR   <= CNT_W'(DVD_W);
      runR   <= 1'b1;
      validR <= 1'b0;
    end else if (runR) begin
      quoR <= {quoR[DVD_W-2:0], fits};
      remR <= nextRem;
      cntR <= cntR - CNT_W'(1);
      if (cntR == CNT_W'(1)) begin
        runR   <= 1'b0;
        validR <= 1'b1;
      end
    end else begin
      validR <= 1'b0;
    end
  end

  assign quo   = quoR;
  assign rem   = remR;
  assign valid = validR;
endmodule

// File: rtl/odc_datapath.sv
module odc_datapath
  import odc_pkg::*;
#(
  parameter int FREQ_W     = 64,
  parameter int INT_W      = 11,
  parameter int FRAC_W     = 32,
  parameter int HS_MAX     = 2046,
  parameter int HS_ODD_MAX = 33,
  parameter int LS_LOG_MAX = 5,
  parameter logic [FREQ_W-1:0] VCO_MIN = 64'd10_800_000_000,
  parameter logic [FREQ_W-1:0] VCO_MAX = 64'd12_206_718_160,
  localparam int HS_W = $clog2(HS_MAX + 1),
  localparam int LS_W = $clog2(LS_LOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  odc_ctrl_t         ctrl,
  input  logic [FREQ_W-1:0] fOut,
  input  logic [FREQ_W-1:0] fXtal,
  output odc_stat_t         stat,
  output logic [LS_W-1:0]   lsLog,
  output logic [HS_W-1:0]   hsDiv,
  output logic [FREQ_W-1:0] fVco,
  output logic [INT_W-1:0]  fbInt,
  output logic [FRAC_W-1:0] fbFrac
);
  localparam int DVD_W  = FREQ_W + FRAC_W;
  localparam int NCAND  = LS_LOG_MAX + 1;
  localparam int WIDE_W = FREQ_W + HS_W + LS_LOG_MAX;

  logic [FREQ_W-1:0] fOutR, fXtalR, minRatioR, fVcoR;
  logic [LS_W-1:0]   lsLogR;
  logic [HS_W-1:0]   hsR;
  logic [INT_W-1:0]  fbIntR;
  logic [FRAC_W-1:0] fbFracR;
  logic              pickFailR, vcoOverR, fbOverR;

  // Shared serial divider
  logic [DVD_W-1:0]  dvd, quo;
  logic [FREQ_W-1:0] dvs, rem;
  logic              divValid;

  assign dvd = ctrl.divSelFb ? {fVcoR, {FRAC_W{1'b0}}} : DVD_W'(VCO_MIN);
  assign dvs = ctrl.divSelFb ? fXtalR : fOutR;

  odc_divider #(.DVD_W(DVD_W), .DVS_W(FREQ_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (ctrl.divGo),
    .dividend (dvd),
    .divisor  (dvs),
    .quo      (quo),
    .rem      (rem),
    .valid    (divValid)
  );

  // One candidate high-speed value per low-speed exponent
  logic [FREQ_W-1:0] cand [NCAND];
  logic [NCAND-1:0]  fitV;

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    assign cand[k] = (minRatioR + FREQ_W'((1 << k) - 1)) >> k;
    assign fitV[k] = cand[k] <= FREQ_W'(HS_MAX);
  end

  logic [LS_W-1:0] pickIdx;
  logic [HS_W-1:0] pickHs;
  logic [HS_W-1:0] pickHsAdj;

  always_comb begin
    pickIdx = '0;
    for (int k = NCAND - 1; k >= 0; k--) begin
      if (fitV[k]) pickIdx = LS_W'(k);
    end
    pickHs    = cand[pickIdx][HS_W-1:0];
    pickHsAdj = pickHs;
    if (pickIdx == '0 && pickHs > HS_W'(HS_ODD_MAX) && pickHs[0])
      pickHsAdj = pickHs + HS_W'(1);
  end

  // VCO frequency from the chosen dividers
  logic [WIDE_W-1:0] vcoWide;
  assign vcoWide = (WIDE_W'(fOutR) * WIDE_W'(hsR)) << lsLogR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fOutR     <= '0;
      fXtalR    <= '0;
      minRatioR <= '0;
      lsLogR    <= '0;
      hsR       <= '0;
      fVcoR     <= '0;
      fbIntR    <= '0;
      fbFracR   <= '0;
      pickFailR <= 1'b0;
      vcoOverR  <= 1'b0;
      fbOverR   <= 1'b0;
    end else begin
      if (ctrl.loadIn) begin
        fOutR  <= fOut;
        fXtalR <= fXtal;
      end
      if (ctrl.takeRatio)
        minRatioR <= quo[FREQ_W-1:0] + FREQ_W'(rem != '0);
      if (ctrl.takePick) begin
        lsLogR    <= pickIdx;
        hsR       <= pickHsAdj;
        pickFailR <= ~|fitV;
      end
      if (ctrl.takeVco) begin
        fVcoR    <= vcoWide[FREQ_W-1:0];
        vcoOverR <= vcoWide > WIDE_W'(VCO_MAX);
      end
      if (ctrl.takeFb) begin
        fbIntR  <= quo[FRAC_W+INT_W-1:FRAC_W];
        fbFracR <= quo[FRAC_W-1:0];
        fbOverR <= |quo[DVD_W-1:FRAC_W+INT_W];
      end
    end
  end

  assign stat.zeroIn   = (fOutR == '0) || (fXtalR == '0);
  assign stat.divValid = divValid;
  assign stat.pickFail = pickFailR;
  assign stat.vcoOver  = vcoOverR;
  assign stat.fbOver   = fbOverR;

  assign lsLog  = lsLogR;
  assign hsDiv  = hsR;
  assign fVco   = fVcoR;
  assign fbInt  = fbIntR;
  assign fbFrac = fbFracR;
endmodule

// File: rtl/odc_control.sv
module odc_control
  import odc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  odc_stat_t stat,
  output odc_ctrl_t ctrl,
  output logic      busy,
  output logic      done,
  output logic      err
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHKIN, S_RATIO, S_PICK, S_PCHK, S_VCHK, S_FB, S_FCHK
  } odc_state_e;

  odc_state_e state, nextState;
  logic       finish, fail;
  logic       doneR, errR;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    finish    = 1'b0;
    fail      = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctrl.loadIn = 1'b1;
        nextState   = S_CHKIN;
      end
      S_CHKIN: if (stat.zeroIn) begin
        fail      = 1'b1;
        nextState = S_IDLE;
      end else begin
        ctrl.divGo = 1'b1;
        nextState  = S_RATIO;
      end
      S_RATIO: if (stat.divValid) begin
        ctrl.takeRatio = 1'b1;
        nextState      = S_PICK;
      end
      S_PICK: begin
        ctrl.takePick = 1'b1;
        nextState     = S_PCHK;
      end
      S_PCHK: if (stat.pickFail) begin
        fail      = 1'b1;
        nextState = S_IDLE;
      end else begin
        ctrl.takeVco = 1'b1;
        nextState    = S_VCHK;
      end
      S_VCHK: if (stat.vcoOver) begin
        fail      = 1'b1;
        nextState = S_IDLE;
      end else begin
        ctrl.divGo    = 1'b1;
        ctrl.divSelFb = 1'b1;
        nextState     = S_FB;
      end
      S_FB: begin
        ctrl.divSelFb = 1'b1;
        if (stat.divValid) begin
          ctrl.takeFb = 1'b1;
          nextState   = S_FCHK;
        end
      end
      S_FCHK: begin
        fail      = stat.fbOver;
        finish    = ~stat.fbOver;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      doneR <= 1'b0;
      errR  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) begin
        doneR <= 1'b0;
        errR  <= 1'b0;
      end
      if (finish || fail) doneR <= 1'b1;
      if (fail) errR <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneR;
  assign err  = errR;
endmodule

// File: rtl/odc_calc.sv
module odc_calc
  import odc_pkg::*;
#(
  parameter int FREQ_W     = 64,
  parameter int INT_W      = 11,
  parameter int FRAC_W     = 32,
  parameter int HS_MAX     = 2046,
  parameter int HS_ODD_MAX = 33,
  parameter int LS_LOG_MAX = 5,
  parameter logic [FREQ_W-1:0] VCO_MIN = 64'd10_800_000_000,
  parameter logic [FREQ_W-1:0] VCO_MAX = 64'd12_206_718_160,
  localparam int HS_W = $clog2(HS_MAX + 1),
  localparam int LS_W = $clog2(LS_LOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] fOut,
  input  logic [FREQ_W-1:0] fXtal,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [LS_W-1:0]   lsLog,
  output logic [HS_W-1:0]   hsDiv,
  output logic [FREQ_W-1:0] fVco,
  output logic [INT_W-1:0]  fbInt,
  output logic [FRAC_W-1:0] fbFrac
);
  odc_ctrl_t ctrl;
  odc_stat_t stat;

  odc_control u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done),
    .err   (err)
  );

  odc_datapath #(
    .FREQ_W(FREQ_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .HS_MAX(HS_MAX),
    .HS_ODD_MAX(HS_ODD_MAX), .LS_LOG_MAX(LS_LOG_MAX),
    .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .fOut   (fOut),
    .fXtal  (fXtal),
    .stat   (stat),
    .lsLog  (lsLog),
    .hsDiv  (hsDiv),
    .fVco   (fVco),
    .fbInt  (fbInt),
    .fbFrac (fbFrac)
  );
endmodule

// File: rtl/odc_checker.sv
module odc_checker #(
  parameter int FREQ_W     = 64,
  parameter int INT_W      = 11,
  parameter int FRAC_W     = 32,
  parameter int HS_MAX     = 2046,
  parameter int HS_ODD_MAX = 33,
  parameter int LS_LOG_MAX = 5,
  parameter logic [FREQ_W-1:0] VCO_MIN = 64'd10_800_000_000,
  parameter logic [FREQ_W-1:0] VCO_MAX = 64'd12_206_718_160,
  localparam int HS_W = $clog2(HS_MAX + 1),
  localparam int LS_W = $clog2(LS_LOG_MAX + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [LS_W-1:0]   lsLog,
  input logic [HS_W-1:0]   hsDiv,
  input logic [FREQ_W-1:0] fVco,
  input logic [INT_W-1:0]  fbInt,
  input logic [FRAC_W-1:0] fbFrac
);
  logic okDone;
  assign okDone = done && !err;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && !done && !err); // R9

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(err) && $stable(lsLog) && $stable(hsDiv)
      && $stable(fVco) && $stable(fbInt) && $stable(fbFrac)); // R11

  AST_HS_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    okDone |-> hsDiv != '0 && hsDiv <= HS_W'(HS_MAX) && lsLog <= LS_W'(LS_LOG_MAX)); // R2

  AST_LS_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    okDone && lsLog != '0 |-> hsDiv > HS_W'(HS_MAX / 2)); // R2

  AST_HS_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    okDone && lsLog == '0 && hsDiv > HS_W'(HS_ODD_MAX) |-> !hsDiv[0]); // R3

  AST_VCO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    okDone |-> fVco >= VCO_MIN && fVco <= VCO_MAX); // R7
endmodule

bind odc_calc odc_checker #(
  .FREQ_W(FREQ_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .HS_MAX(HS_MAX),
  .HS_ODD_MAX(HS_ODD_MAX), .LS_LOG_MAX(LS_LOG_MAX),
  .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)
) u_chk (.*);

// File: tb/tb_odc_calc.sv
`timescale 1ns/1ps
module tb_odc_calc;
  localparam logic [127:0] VMIN = 128'd10_800_000_000;
  localparam logic [127:0] VMAX = 128'd12_206_718_160;
  localparam int NV = 16;

  // Stimulus table: output frequency and crystal frequency in Hz
  localparam logic [63:0] VEC_OUT [NV] = '{
    64'd156_750_000, 64'd100_000_000, 64'd312_500_000, 64'd400_000_000,
    64'd330_000_000, 64'd5_000_000,   64'd1_000_000,   64'd200_000,
    64'd100_000,     64'd12_300_000_000, 64'd10_800_000_000, 64'd100_000_000,
    64'd0,           64'd5_278_593,   64'd5_278_592,   64'd161_132_812
  };
  localparam logic [63:0] VEC_XTAL [NV] = '{
    64'd152_600_000, 64'd152_600_000, 64'd152_600_000, 64'd152_600_000,
    64'd152_600_000, 64'd152_600_000, 64'd152_600_000, 64'd152_600_000,
    64'd152_600_000, 64'd152_600_000, 64'd152_600_000, 64'd1_000_000,
    64'd152_600_000, 64'd152_600_000, 64'd152_600_000, 64'd0
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] fOut = '0, fXtal = '0;
  logic        busy, done, err;
  logic [2:0]  lsLog;
  logic [10:0] hsDiv;
  logic [63:0] fVco;
  logic [10:0] fbInt;
  logic [31:0] fbFrac;

  int checks = 0;
  int errors = 0;
  bit summaryDone = 0;

  always #2 clk = ~clk;

  odc_calc dut (
    .clk(clk), .rstN(rstN), .start(start), .fOut(fOut), .fXtal(fXtal),
    .busy(busy), .done(done), .err(err), .lsLog(lsLog), .hsDiv(hsDiv),
    .fVco(fVco), .fbInt(fbInt), .fbFrac(fbFrac)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Expected settings computed from the requirements
  task automatic model(input logic [63:0] fo, input logic [63:0] fx, output bit e,
                       output logic [63:0] ls, output logic [63:0] hs,
                       output logic [63:0] vco, output logic [63:0] fbI,
                       output logic [63:0] fbF);
    logic [127:0] minR, c, v, q;
    bit found;
    e = 0; ls = 0; hs = 0; vco = 0; fbI = 0; fbF = 0; found = 0;
    if (fo == 0 || fx == 0) begin e = 1; return; end
    minR = (VMIN + 128'(fo) - 1) / 128'(fo);
    for (int k = 0; k <= 5; k++) begin
      c = (minR + (128'd1 << k) - 1) >> k;
      if (!found && c <= 128'd2046) begin found = 1; ls = 64'(k); hs = c[63:0]; end
    end
    if (!found) begin e = 1; return; end
    if (ls == 0 && hs > 33 && hs[0]) hs = hs + 1;
    v = (128'(fo) * 128'(hs)) << ls;
    if (v > VMAX) begin e = 1; return; end
    vco = v[63:0];
    q = (v << 32) / 128'(fx);
    if ((q >> 43) != 0) begin e = 1; return; end
    fbI = 64'(q[42:32]);
    fbF = 64'(q[31:0]);
  endtask

  task automatic launch(input logic [63:0] fo, input logic [63:0] fx);
    @(negedge clk);
    fOut = fo; fXtal = fx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done, tag, 64'(done), 64'd1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    bit e;
    logic [63:0] ls, hs, vco, fbI, fbF;

    // Reset state (R9)
    #1;
    check(!busy && !done && !err, "R9 reset state", {61'd0, busy, done, err}, 64'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R9 idle after reset", {62'd0, busy, done}, 64'd0);

    // Table walk (R1..R8)
    for (int i = 0; i < NV; i++) begin
      model(VEC_OUT[i], VEC_XTAL[i], e, ls, hs, vco, fbI, fbF);
      launch(VEC_OUT[i], VEC_XTAL[i]);
      check(busy && !done && !err, "R9 start accepted", {61'd0, busy, done, err}, 64'd4);
      waitDone("R9 done reached");
      check(err == e, "R6 R7 R8 error flag", 64'(err), 64'(e));
      if (!e && !err) begin
        check(64'(lsLog) == ls, "R2 low-speed log", 64'(lsLog), ls);
        check(64'(hsDiv) == hs, "R1 R3 high-speed ratio", 64'(hsDiv), hs);
        check(fVco == vco, "R4 VCO frequency", fVco, vco);
        check(64'(fbInt) == fbI, "R5 feedback integer", 64'(fbInt), fbI);
        check(64'(fbFrac) == fbF, "R5 feedback fraction", 64'(fbFrac), fbF);
      end
    end

    // Golden example (R12)
    launch(64'd156_750_000, 64'd152_600_000);
    waitDone("R12 done");
    check(!err && lsLog == 3'd0, "R12 lsLog", 64'(lsLog), 64'd0);
    check(hsDiv == 11'd70, "R12 hsDiv", 64'(hsDiv), 64'd70);
    check(fVco == 64'd10_972_500_000, "R12 fVco", fVco, 64'd10_972_500_000);
    check({fbInt, fbFrac} == 43'h047E756E62A, "R12 feedback", 64'({fbInt, fbFrac}),
          64'h047E756E62A);

    // Start while busy is ignored (R10)
    launch(64'd312_500_000, 64'd152_600_000);
    repeat (10) @(negedge clk);
    fOut = 64'd1_000_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R10 done");
    check(!err && hsDiv == 11'd36 && lsLog == 3'd0, "R10 first run kept", 64'(hsDiv), 64'd36);
    @(negedge clk);
    check(!busy, "R10 no second run", 64'(busy), 64'd0);

    // Outputs hold after done while inputs move (R11)
    fOut = 64'd200_000; fXtal = 64'd1;
    repeat (30) @(negedge clk);
    check(done && hsDiv == 11'd36 && fVco == 64'd11_250_000_000, "R11 hold",
          fVco, 64'd11_250_000_000);

    // Error cleared by next start (R9)
    launch(64'd100_000, 64'd152_600_000);
    waitDone("R6 done");
    check(err, "R6 out of reach", 64'(err), 64'd1);
    launch(64'd400_000_000, 64'd152_600_000);
    check(!err && !done, "R9 flags cleared", {62'd0, done, err}, 64'd0);
    waitDone("R3 done");
    check(hsDiv == 11'd27, "R3 odd below limit kept", 64'(hsDiv), 64'd27);

    finishRun();
  end
endmodule